// File: doc/BRIEF.md
# Host Boot-Ready Wait Controller

This block sits on the host side and holds back bus enumeration until an attached accelerator card says its operating system is up. A pulse on `start` begins a fixed sequence of reads over a single-outstanding read port. The first read fetches the device class code. The second fetches the device's own worst-case boot time in seconds. After that the block polls the OS status word until the device reports booted or the boot-time budget runs out.

The budget is counted by a seconds prescaler that runs from the block clock. When the wait ends, the block raises a one-cycle `done` strobe and a two-bit result code. It also holds either `proceed` (enumeration may continue) or `fail` (the host should give up on the device), and shows the last status code it read. A device whose class code does not match the expected value is not waited for: it is passed through at once and marked as not applicable. A new `start` pulse re-arms the block for another round.

Top module: `bootwait_ctrl`

## Requirements
- R1: While `rst_n` is low on a clock edge, `rd_req`, `done`, `proceed` and `fail` are cleared, `result` is 0 and `os_status` is 0.
- R2: After `start` is accepted from idle or finished, the reads go in this order: class code at `ADDR_CLASS`, boot-time budget at `ADDR_BUDGET`, then OS status at `ADDR_STATUS`. At most one read is outstanding. `rd_req` and `rd_addr` stay unchanged until the cycle in which `rd_ack` is high.
- R3: If `rd_data[23:0]` of the class read differs from `CLASS_CODE`, no further read is issued. `done` pulses with result 3 (not applicable) and `proceed` is set.
- R4: The budget is `rd_data[15:0]` in seconds, clamped to 1600. It expires after that many periods of `TICKS_PER_SEC` clock cycles, counted from the first cycle after the budget read completes.
- R5: The status code is `rd_data[2:0]`: 0 not started, 1 booting, 2 booted, 3 stalled, 4 halted. Codes 5 to 7 count as still booting. Booted ends the wait with result 0 (ready) and sets `proceed`.
- R6: A stalled (3) or halted (4) status ends the wait at once with result 2 (error) and sets `fail`.
- R7: A status read other than 2, 3 or 4 that completes after expiry ends the wait with result 1 (timeout) and sets `fail`. So does expiry while waiting between polls. A budget of 0 gives exactly one status read.
- R8: After a status read that does not end the wait, the next status request is raised `POLL_GAP` cycles after the completing cycle.
- R9: A booted status wins over an expired budget: a booted reply that arrives after expiry still yields result 0.
- R10: `done` is a single-cycle pulse that comes once per round. `proceed` and `fail` are never both high. They hold with `result` until the next accepted `start`, which clears them.
- R11: `os_status` shows the code from the most recent completed status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin or re-arm a wait round (accepted when idle or finished) |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | AW | Register address of the pending read |
| rd_ack | input | 1 | Read completion; `rd_data` is valid in this cycle |
| rd_data | input | DW | Read data |
| done | output | 1 | One-cycle strobe when the round ends |
| result | output | 2 | 0 ready, 1 timeout, 2 error, 3 not applicable |
| proceed | output | 1 | Enumeration may continue |
| fail | output | 1 | Device timed out or reported a fault |
| os_status | output | 3 | Last OS status code read |

## Verification
Two events can land on the same decision: the budget running out and a status reply coming back. The bench provokes this by setting a one-second budget and a read latency longer than one second of ticks. The status reply then completes only after the deadline has already passed. It is run once with a booted reply, which must yield ready, and once with a booting reply, which must yield timeout after exactly one status read. A behavioural model in the bench tracks the same race cycle by cycle and flags any difference on the read port, the result or the flags.

// File: rtl/bootwait_pkg.sv
// Shared types for the boot-ready wait controller.
// Assumes: result encoding is fixed and visible at the top ports.
package bootwait_pkg;

    typedef enum logic [1:0] {
        RES_READY   = 2'd0,
        RES_TIMEOUT = 2'd1,
        RES_ERROR   = 2'd2,
        RES_NA      = 2'd3
    } res_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLASS,
        ST_BUDGET,
        ST_STATUS,
        ST_GAP,
        ST_FIN
    } st_e;

    localparam logic [2:0] OS_BOOTED  = 3'd2;
    localparam logic [2:0] OS_STALLED = 3'd3;
    localparam logic [2:0] OS_HALTED  = 3'd4;

endpackage

// File: rtl/bw_sec_timer.sv
// Deadline counter in whole seconds with a clock-cycle prescaler.
// Assumes: load and run are never high together; expired means zero seconds left.
module bw_sec_timer #(
    parameter int TICKS_PER_SEC = 200_000_000,
    parameter int MAX_SECS      = 1600,
    localparam int SW = $clog2(MAX_SECS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [SW-1:0] load_secs,
    input  logic          run,
    output logic          expired
);

    logic          tick;
    logic [SW-1:0] secs;

    generate
        if (TICKS_PER_SEC > 1) begin : g_presc
            localparam int PW = $clog2(TICKS_PER_SEC);
            logic [PW-1:0] presc;
            // Count cycles within the current second.
            always_ff @(posedge clk) begin
                if (!rst_n || load) begin
                    presc <= '0;
                end else if (run) begin
                    presc <= (presc == PW'(TICKS_PER_SEC - 1)) ? '0 : presc + 1'b1;
                end
            end
            assign tick = run && (presc == PW'(TICKS_PER_SEC - 1));
        end else begin : g_nopresc
            assign tick = run;
        end
    endgenerate

    // Seconds remaining: loaded from the device budget, counted down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            secs <= '0;
        end else if (load) begin
            secs <= load_secs;
        end else if (tick && secs != '0) begin
            secs <= secs - 1'b1;
        end
    end

    assign expired = (secs == '0);

    p_budget_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> secs <= $past(secs));
    p_expiry_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expired && !load |=> expired);

endmodule

// File: rtl/bw_poll_gap.sv
// Spacing counter between consecutive status polls.
// Assumes: POLL_GAP >= 1; clear is pulsed on the cycle before the gap begins.
module bw_poll_gap #(
    parameter int POLL_GAP = 64,
    localparam int GW = $clog2(POLL_GAP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic elapsed
);

    logic [GW-1:0] cnt;

    // Count the cycles spent waiting since the last poll completed.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign elapsed = (cnt == GW'(POLL_GAP - 1));

    p_gap_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt < GW'(POLL_GAP));

endmodule

// File: rtl/bw_seq.sv
// Sequencer: class read, budget read, status polling, result reporting.
// Assumes: rd_data[23:0] carries the class code, [15:0] the budget, [2:0] the status.
module bw_seq
    import bootwait_pkg::*;
#(
    parameter int          AW          = 12,
    parameter int          DW          = 32,
    parameter int          MAX_SECS    = 1600,
    parameter logic [23:0] CLASS_CODE  = 24'h120000,
    parameter int          ADDR_CLASS  = 'h008,
    parameter int          ADDR_BUDGET = 'h100,
    parameter int          ADDR_STATUS = 'h104,
    localparam int SW = $clog2(MAX_SECS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    input  logic          expired,
    input  logic          gap_elapsed,
    output logic          tmr_load,
    output logic [SW-1:0] tmr_secs,
    output logic          tmr_run,
    output logic          gap_clear,
    output logic          gap_run,
    output logic          done,
    output res_e          result,
    output logic          proceed,
    output logic          fail,
    output logic [2:0]    os_status
);

    st_e         st;
    logic [15:0] budget_raw;
    logic [2:0]  code;
    logic        unused_hi;

    assign budget_raw = rd_data[15:0];
    assign code       = rd_data[2:0];
    assign unused_hi  = ^rd_data[DW-1:24];

    // Read port and helper-counter controls decoded from the state.
    always_comb begin
        rd_req  = (st == ST_CLASS) || (st == ST_BUDGET) || (st == ST_STATUS);
        case (st)
            ST_CLASS:  rd_addr = AW'(ADDR_CLASS);
            ST_BUDGET: rd_addr = AW'(ADDR_BUDGET);
            default:   rd_addr = AW'(ADDR_STATUS);
        endcase
        tmr_load  = (st == ST_BUDGET) && rd_ack;
        tmr_secs  = (budget_raw > 16'(MAX_SECS)) ? SW'(MAX_SECS) : SW'(budget_raw);
        tmr_run   = (st == ST_STATUS) || (st == ST_GAP);
        gap_clear = (st == ST_STATUS) && rd_ack;
        gap_run   = (st == ST_GAP);
    end

    // State sequencing and registered result reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            done      <= 1'b0;
            result    <= RES_READY;
            proceed   <= 1'b0;
            fail      <= 1'b0;
            os_status <= 3'd0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE, ST_FIN: begin
                    if (start) begin
                        st      <= ST_CLASS;
                        proceed <= 1'b0;
                        fail    <= 1'b0;
                    end
                end
                ST_CLASS: begin
                    if (rd_ack) begin
                        if (rd_data[23:0] != CLASS_CODE) begin
                            st <= ST_FIN; done <= 1'b1; result <= RES_NA; proceed <= 1'b1;
                        end else begin
                            st <= ST_BUDGET;
                        end
                    end
                end
                ST_BUDGET: begin
                    if (rd_ack) st <= ST_STATUS;
                end
                ST_STATUS: begin
                    if (rd_ack) begin
                        os_status <= code;
                        if (code == OS_BOOTED) begin
                            st <= ST_FIN; done <= 1'b1; result <= RES_READY; proceed <= 1'b1;
                        end else if (code == OS_STALLED || code == OS_HALTED) begin
                            st <= ST_FIN; done <= 1'b1; result <= RES_ERROR; fail <= 1'b1;
                        end else if (expired) begin
                            st <= ST_FIN; done <= 1'b1; result <= RES_TIMEOUT; fail <= 1'b1;
                        end else begin
                            st <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    if (expired) begin
                        st <= ST_FIN; done <= 1'b1; result <= RES_TIMEOUT; fail <= 1'b1;
                    end else if (gap_elapsed) begin
                        st <= ST_STATUS;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    p_one_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr));
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(proceed && fail));
    p_proceed_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        proceed && !start |=> proceed);
    p_ready_proceed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done && result == RES_READY |-> proceed);
    p_error_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && result == RES_ERROR |-> fail);
    p_timeout_expired_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && result == RES_TIMEOUT |-> expired);

endmodule

// File: rtl/bootwait_ctrl.sv
// Top: host-side wait for an accelerator to report a booted OS.
// Assumes: one outstanding read; the device supplies its own boot budget.
module bootwait_ctrl #(
    parameter int          AW            = 12,
    parameter int          DW            = 32,
    parameter int          TICKS_PER_SEC = 200_000_000,
    parameter int          MAX_SECS      = 1600,
    parameter int          POLL_GAP      = 64,
    parameter logic [23:0] CLASS_CODE    = 24'h120000,
    parameter int          ADDR_CLASS    = 'h008,
    parameter int          ADDR_BUDGET   = 'h100,
    parameter int          ADDR_STATUS   = 'h104
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          done,
    output logic [1:0]    result,
    output logic          proceed,
    output logic          fail,
    output logic [2:0]    os_status
);

    localparam int SW = $clog2(MAX_SECS + 1);

    logic                 expired, gap_elapsed;
    logic                 tmr_load, tmr_run, gap_clear, gap_run;
    logic [SW-1:0]        tmr_secs;
    bootwait_pkg::res_e   res;

    assign result = res;

    bw_seq #(
        .AW(AW), .DW(DW), .MAX_SECS(MAX_SECS), .CLASS_CODE(CLASS_CODE),
        .ADDR_CLASS(ADDR_CLASS), .ADDR_BUDGET(ADDR_BUDGET), .ADDR_STATUS(ADDR_STATUS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .expired(expired), .gap_elapsed(gap_elapsed),
        .tmr_load(tmr_load), .tmr_secs(tmr_secs), .tmr_run(tmr_run),
        .gap_clear(gap_clear), .gap_run(gap_run),
        .done(done), .result(res), .proceed(proceed), .fail(fail), .os_status(os_status)
    );

    bw_sec_timer #(.TICKS_PER_SEC(TICKS_PER_SEC), .MAX_SECS(MAX_SECS)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_secs(tmr_secs),
        .run(tmr_run), .expired(expired)
    );

    bw_poll_gap #(.POLL_GAP(POLL_GAP)) u_gap (
        .clk(clk), .rst_n(rst_n), .clear(gap_clear), .run(gap_run), .elapsed(gap_elapsed)
    );

endmodule

// File: tb/test_bootwait_ctrl.sv
`timescale 1ns/1ps
module test_bootwait_ctrl;

    localparam int          TPS   = 20;
    localparam int          GAP   = 4;
    localparam int          AW    = 8;
    localparam int          A_CLS = 8;
    localparam int          A_BUD = 16;
    localparam int          A_ST  = 20;
    localparam logic [23:0] CLS   = 24'h0B4001;

    logic          clk = 0, rst_n = 0, start = 0, rd_ack = 0;
    logic [31:0]   rd_data = '0;
    logic          rd_req, done, proceed, fail;
    logic [AW-1:0] rd_addr;
    logic [1:0]    result;
    logic [2:0]    os_status;

    bootwait_ctrl #(
        .AW(AW), .DW(32), .TICKS_PER_SEC(TPS), .MAX_SECS(1600), .POLL_GAP(GAP),
        .CLASS_CODE(CLS), .ADDR_CLASS(A_CLS), .ADDR_BUDGET(A_BUD), .ADDR_STATUS(A_ST)
    ) i_bootwait_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .done(done), .result(result),
        .proceed(proceed), .fail(fail), .os_status(os_status)
    );

    always #2.5 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Device responder: acknowledges after a latency, one cycle gap between reads.
    int dev_cls, dev_bud, lat, wcnt = 0, n_cls, n_bud, n_st, t_bud;
    int st_q[$];
    int addr_log[$];
    always @(negedge clk) begin
        if (rd_ack) begin
            rd_ack = 0; wcnt = 0;
        end else if (rst_n && rd_req) begin
            if (wcnt >= lat) begin
                rd_ack = 1;
                addr_log.push_back(int'(rd_addr));
                if (int'(rd_addr) == A_CLS) begin
                    rd_data = {8'h5A, dev_cls[23:0]}; n_cls++;
                end else if (int'(rd_addr) == A_BUD) begin
                    rd_data = {16'hC3C3, dev_bud[15:0]}; n_bud++; t_bud = cyc;
                end else begin
                    int v;
                    v = (st_q.size() > 1) ? st_q.pop_front() : st_q[0];
                    rd_data = {29'h1ABCDE0, v[2:0]}; n_st++;
                end
            end else begin
                wcnt++;
            end
        end
    end

    // Behavioural reference model, advanced on every clock.
    int m_st = 0, m_secs = 0, m_presc = 0, m_gap = 0, m_res = 0, m_os = 0;
    bit m_done = 0, m_proc = 0, m_fail = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_secs = 0; m_presc = 0; m_gap = 0; m_res = 0; m_os = 0;
            m_done = 0; m_proc = 0; m_fail = 0;
        end else begin
            int ost, osecs, c;
            ost = m_st; osecs = m_secs; c = int'(rd_data[2:0]);
            m_done = 0;
            if ((ost == 0 || ost == 5) && start) begin
                m_st = 1; m_proc = 0; m_fail = 0;
            end else if (ost == 1 && rd_ack) begin
                if (rd_data[23:0] != CLS) begin m_st = 5; m_done = 1; m_res = 3; m_proc = 1; end
                else m_st = 2;
            end else if (ost == 2 && rd_ack) begin
                m_secs = (int'(rd_data[15:0]) > 1600) ? 1600 : int'(rd_data[15:0]);
                m_presc = 0; m_st = 3;
            end else if (ost == 3 && rd_ack) begin
                m_os = c;
                if (c == 2) begin m_st = 5; m_done = 1; m_res = 0; m_proc = 1; end
                else if (c == 3 || c == 4) begin m_st = 5; m_done = 1; m_res = 2; m_fail = 1; end
                else if (osecs == 0) begin m_st = 5; m_done = 1; m_res = 1; m_fail = 1; end
                else begin m_st = 4; m_gap = 0; end
            end else if (ost == 4) begin
                if (osecs == 0) begin m_st = 5; m_done = 1; m_res = 1; m_fail = 1; end
                else if (m_gap == GAP - 1) m_st = 3;
                else m_gap++;
            end
            if (ost == 3 || ost == 4) begin
                if (m_presc == TPS - 1) begin
                    m_presc = 0;
                    if (osecs != 0) m_secs = osecs - 1;
                end else m_presc++;
            end
        end
    end

    // Compare the design against the model away from the active edge.
    int n_done = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit m_req;
            int m_addr;
            m_req  = (m_st >= 1 && m_st <= 3);
            m_addr = (m_st == 1) ? A_CLS : (m_st == 2) ? A_BUD : A_ST;
            if (done) n_done++;
            chk(rd_req == m_req, "R2", "rd_req vs model", int'(rd_req), int'(m_req));
            if (m_req) chk(int'(rd_addr) == m_addr, "R2", "rd_addr vs model", int'(rd_addr), m_addr);
            chk(done == m_done, "R10", "done vs model", int'(done), int'(m_done));
            chk(int'(result) == m_res, "R10", "result vs model", int'(result), m_res);
            chk(proceed == m_proc, "R5", "proceed vs model", int'(proceed), int'(m_proc));
            chk(fail == m_fail, "R7", "fail vs model", int'(fail), int'(m_fail));
            chk(int'(os_status) == m_os, "R11", "os_status vs model", int'(os_status), m_os);
        end
    end

    int t_done;
    task automatic run_round(input int cls, input int bud, input int l, input int q[$]);
        int g;
        dev_cls = cls; dev_bud = bud; lat = l; st_q = q;
        n_cls = 0; n_bud = 0; n_st = 0; n_done = 0; t_bud = 0; t_done = -1;
        addr_log.delete();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk(!proceed && !fail, "R10", "flags cleared by start", int'(proceed) + 2 * int'(fail), 0);
        g = 0;
        while (!done && g < 40000) begin @(negedge clk); g++; end
        t_done = cyc;
        repeat (3) @(negedge clk);
        chk(n_done == 1, "R10", "single done pulse", n_done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!rd_req && !done && !proceed && !fail && result == 2'd0 && os_status == 3'd0,
            "R1", "reset state", int'(rd_req) + int'(done) + int'(proceed) + int'(fail), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // Booted after two booting polls.
        run_round(int'(CLS), 5, 0, '{1, 1, 2});
        chk(addr_log.size() >= 3 && addr_log[0] == A_CLS && addr_log[1] == A_BUD && addr_log[2] == A_ST,
            "R2", "read order", addr_log.size() > 1 ? addr_log[1] : -1, A_BUD);
        chk(result == 2'd0 && proceed, "R5", "booted result", int'(result), 0);
        chk(n_st == 3, "R8", "status polls", n_st, 3);
        chk(os_status == 3'd2, "R11", "last status", int'(os_status), 2);
        chk(proceed && !fail, "R10", "proceed held", int'(proceed), 1);

        // Class mismatch: pass-through, no further reads.
        run_round(24'h020000, 5, 2, '{1});
        chk(result == 2'd3 && proceed, "R3", "not applicable result", int'(result), 3);
        chk(n_bud + n_st == 0 && n_cls == 1, "R3", "reads after mismatch", n_bud + n_st, 0);

        // Stalled after not-started.
        run_round(int'(CLS), 5, 1, '{0, 3});
        chk(result == 2'd2 && fail && !proceed, "R6", "stalled result", int'(result), 2);
        chk(os_status == 3'd3, "R11", "stalled code", int'(os_status), 3);

        // Halted on first poll.
        run_round(int'(CLS), 5, 0, '{4});
        chk(result == 2'd2 && fail, "R6", "halted result", int'(result), 2);

        // Unknown code counts as booting, then booted.
        run_round(int'(CLS), 5, 0, '{6, 7, 2});
        chk(result == 2'd0 && n_st == 3, "R5", "codes 5-7 keep waiting", n_st, 3);

        // Two-second timeout.
        run_round(int'(CLS), 2, 0, '{1});
        chk(result == 2'd1 && fail, "R7", "timeout result", int'(result), 1);
        chk(t_done - t_bud >= 2 * TPS && t_done - t_bud <= 2 * TPS + GAP + 6,
            "R4", "deadline span", t_done - t_bud, 2 * TPS);

        // Zero budget: exactly one status read.
        run_round(int'(CLS), 0, 1, '{1});
        chk(result == 2'd1 && n_st == 1, "R7", "zero budget reads", n_st, 1);

        // Expired budget with booted reply still ready.
        run_round(int'(CLS), 1, 30, '{2});
        chk(result == 2'd0 && proceed && n_st == 1, "R9", "booted beats expiry", int'(result), 0);

        // Expired budget with booting reply times out after one read.
        run_round(int'(CLS), 1, 30, '{1});
        chk(result == 2'd1 && n_st == 1, "R9", "late booting reply", int'(result), 1);

        // Budget above the limit is clamped.
        run_round(int'(CLS), 5000, 0, '{1});
        chk(result == 2'd1, "R4", "clamped budget result", int'(result), 1);
        chk(t_done - t_bud >= 1600 * TPS && t_done - t_bud <= 1600 * TPS + GAP + 6,
            "R4", "clamped deadline span", t_done - t_bud, 1600 * TPS);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule